// File: doc/BRIEF.md
# Buffered Serial Flash Page Program Engine

This block writes one page-program sequence to a serial NOR flash over single-lane SPI. Software fills registers over a simple word-addressed register port: the program opcode, four address bytes, an address-width select, a single payload byte, and configuration bits. It then sets a start bit in the control register. The engine drives the chip select, the serial clock and the data line through the whole sequence. It raises chip select between frames and clears the start bit when the flash reports that it is idle.

Two payload kinds exist. In unbuffered mode exactly one byte goes out, taken from the byte register. In buffered mode a full 128-byte page goes out. Software stages that page beforehand through a 32-bit port, in words with the earliest wire byte in the low lane. Buffered mode has an enable/acknowledge handshake: software writes the enable bit and then polls until the read-back value matches. The engine may also send a write-enable frame before the program frame, and it may poll the status register afterwards. Each of these steps can be switched off.

The payload port is a plain register write with no back-pressure. Words beyond the page size are dropped rather than stalled, and every register write issued while a sequence runs is discarded.

Top module: `page_prog_engine`

## Requirements
- R1: After reset the engine is idle, chip select is high, the serial clock is low, and every register reads as zero.
- R2: A register write to CTRL (word address 0) with bit 4 set while idle starts a sequence. CTRL bit 4 reads 1 from the next cycle until the sequence finishes, and then reads 0.
- R3: The program opcode on the wire is 0x02, unless WRCFG (word address 7) bit 4 is set. In that case it is the byte held in OPCODE (word address 1).
- R4: After the opcode the address goes out most significant byte first. ADDR0, ADDR1 and ADDR2 (word addresses 2, 3 and 4) hold bits 7:0, 15:8 and 23:16. When BUSMODE (word address 6) bit 4 is set, a fourth byte from ADDR3 (word address 5) is sent first.
- R5: Unless AUTOCFG (word address 8) bit 7 is set, a separate chip-select frame carrying only 0x06 comes before the program frame.
- R6: Unless AUTOCFG bit 5 is set, after the program frame a frame starts with 0x05 and then clocks 0x00 status bytes until a returned byte has bit 0 clear. The sequence ends only after that byte.
- R7: Writing WRCFG bit 0 requests buffered mode. WRCFG bit 0 reads back the acknowledged state, which follows the written value two cycles after the write. The acknowledged state at start selects the payload kind.
- R8: In buffered mode the payload is 128 bytes from the staged words, in order, with bits 7:0 of each word first on the wire.
- R9: Writes to PAGE (word address 10) fill the buffer; writes after 32 words are dropped. The fill position returns to word 0 when a sequence starts.
- R10: In unbuffered mode the payload is exactly one byte, bits 7:0 of BYTE (word address 9).
- R11: While a sequence runs, all register writes, including a second start, have no effect.
- R12: SPI mode 0, MSB first. The clock idles low and data changes only while the clock is low. Chip select stays high for exactly CS_GAP clock cycles between the frames of one sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The hardest state to reach is a long status poll after a full 128-byte page. It needs the buffer handshake completed, an overfilled buffer, and a flash that stays busy for several status bytes. The bench's flash model returns a busy status for a programmable number of status bytes. Directed runs enable the handshake, push 33 words and hold the model busy. Another run injects writes and a second start while a page is still in flight. Random runs then vary address width, opcode source, automatic steps and busy length.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
  localparam int unsigned RA_W = 4;

  localparam logic [RA_W-1:0] RA_CTRL    = 4'd0;
  localparam logic [RA_W-1:0] RA_OPCODE  = 4'd1;
  localparam logic [RA_W-1:0] RA_ADDR0   = 4'd2;
  localparam logic [RA_W-1:0] RA_ADDR1   = 4'd3;
  localparam logic [RA_W-1:0] RA_ADDR2   = 4'd4;
  localparam logic [RA_W-1:0] RA_ADDR3   = 4'd5;
  localparam logic [RA_W-1:0] RA_BUSMODE = 4'd6;
  localparam logic [RA_W-1:0] RA_WRCFG   = 4'd7;
  localparam logic [RA_W-1:0] RA_AUTOCFG = 4'd8;
  localparam logic [RA_W-1:0] RA_BYTE    = 4'd9;
  localparam logic [RA_W-1:0] RA_PAGE    = 4'd10;

  localparam int unsigned B_GO       = 4;
  localparam int unsigned B_FOURB    = 4;
  localparam int unsigned B_BUFEN    = 0;
  localparam int unsigned B_CUSTOP   = 4;
  localparam int unsigned B_NOWREN   = 7;
  localparam int unsigned B_NOPOLL   = 5;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_PROG = 8'h02;

  typedef enum logic [2:0] {
    S_IDLE, S_WREN, S_GAP, S_PROG, S_POLL_OP, S_POLL_RD, S_DONE
  } seq_st_t;

  typedef struct packed {
    logic        four_b;
    logic        buffered;
    logic        no_wren;
    logic        no_poll;
    logic [7:0]  opcode;
    logic [31:0] addr;
    logic [7:0]  byte0;
  } job_t;
endpackage

// File: rtl/ppe_regs.sv
module ppe_regs
  import ppe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [RA_W-1:0] addr,
  input  logic [31:0]     wdata,
  input  logic            busy,
  output logic [31:0]     rdata,
  output logic            start,
  output job_t            job,
  output logic            page_wr,
  output logic [31:0]     page_data,
  output logic            buf_req,
  output logic            buf_ack,
  output logic [7:0]      opc_q
);
  logic [3:0][7:0] addr_q;
  logic [7:0]      byte_q;
  logic            four_q, cust_q, nowren_q, nopoll_q;
  logic            req_q, sync_q, ack_q;
  logic            wr_ok;

  assign wr_ok = wr && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opc_q    <= '0;
      addr_q   <= '0;
      byte_q   <= '0;
      four_q   <= 1'b0;
      cust_q   <= 1'b0;
      nowren_q <= 1'b0;
      nopoll_q <= 1'b0;
      req_q    <= 1'b0;
    end else if (wr_ok) begin
      case (addr)
        RA_OPCODE:  opc_q     <= wdata[7:0];
        RA_ADDR0:   addr_q[0] <= wdata[7:0];
        RA_ADDR1:   addr_q[1] <= wdata[7:0];
        RA_ADDR2:   addr_q[2] <= wdata[7:0];
        RA_ADDR3:   addr_q[3] <= wdata[7:0];
        RA_BUSMODE: four_q    <= wdata[B_FOURB];
        RA_WRCFG: begin
          req_q  <= wdata[B_BUFEN];
          cust_q <= wdata[B_CUSTOP];
        end
        RA_AUTOCFG: begin
          nowren_q <= wdata[B_NOWREN];
          nopoll_q <= wdata[B_NOPOLL];
        end
        RA_BYTE:    byte_q    <= wdata[7:0];
        default: ;
      endcase
    end
  end

  // two-stage acknowledge of the buffered-mode request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      sync_q <= req_q;
      ack_q  <= sync_q;
    end
  end

  assign start     = wr_ok && (addr == RA_CTRL) && wdata[B_GO];
  assign page_wr   = wr_ok && (addr == RA_PAGE);
  assign page_data = wdata;
  assign buf_req   = req_q;
  assign buf_ack   = ack_q;

  always_comb begin
    job.four_b   = four_q;
    job.buffered = ack_q;
    job.no_wren  = nowren_q;
    job.no_poll  = nopoll_q;
    job.opcode   = cust_q ? opc_q : OP_PROG;
    job.addr     = addr_q;
    job.byte0    = byte_q;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL:    rdata[B_GO]     = busy;
      RA_OPCODE:  rdata[7:0]      = opc_q;
      RA_ADDR0:   rdata[7:0]      = addr_q[0];
      RA_ADDR1:   rdata[7:0]      = addr_q[1];
      RA_ADDR2:   rdata[7:0]      = addr_q[2];
      RA_ADDR3:   rdata[7:0]      = addr_q[3];
      RA_BUSMODE: rdata[B_FOURB]  = four_q;
      RA_WRCFG: begin
        rdata[B_BUFEN]  = ack_q;
        rdata[B_CUSTOP] = cust_q;
      end
      RA_AUTOCFG: begin
        rdata[B_NOWREN] = nowren_q;
        rdata[B_NOPOLL] = nopoll_q;
      end
      RA_BYTE:    rdata[7:0]      = byte_q;
      default:    rdata           = '0;
    endcase
  end
endmodule

// File: rtl/ppe_page_buf.sv
module ppe_page_buf #(
  parameter int unsigned WORDS = 32,
  localparam int unsigned LANES = 4,
  localparam int unsigned PW    = $clog2(WORDS + 1),
  localparam int unsigned WI_W  = $clog2(WORDS),
  localparam int unsigned BI_W  = $clog2(WORDS * LANES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr,
  input  logic [31:0]     wdata,
  input  logic [BI_W-1:0] rd_idx,
  output logic [7:0]      rd_byte,
  output logic [PW-1:0]   fill
);
  logic                    room;
  logic [LANES-1:0][7:0]   lane_rd;

  assign room = fill < PW'(WORDS);

  always_ff @(posedge clk) begin
    if (!rst_n)           fill <= '0;
    else if (clr)         fill <= '0;
    else if (wr && room)  fill <= fill + PW'(1);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [WORDS];
    always_ff @(posedge clk) begin
      if (wr && room && !clr) lane_mem[fill[WI_W-1:0]] <= wdata[8*g +: 8];
    end
    assign lane_rd[g] = lane_mem[rd_idx[BI_W-1:2]];
  end

  assign rd_byte = lane_rd[rd_idx[1:0]];
endmodule

// File: rtl/ppe_spi_shift.sv
module ppe_spi_shift #(
  parameter int unsigned DIV = 2,
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  output logic       done,
  output logic [7:0] rx,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  logic          active, sclk_q, done_q;
  logic [DW-1:0] div_cnt;
  logic [2:0]    bitc;
  logic [7:0]    sh, rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
      div_cnt <= '0;
      bitc    <= '0;
      sh      <= '0;
      rx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (go) begin
          active  <= 1'b1;
          sh      <= tx;
          bitc    <= '0;
          div_cnt <= '0;
          sclk_q  <= 1'b0;
        end
      end else if (div_cnt == DW'(DIV - 1)) begin
        div_cnt <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso};
        end else begin
          sclk_q <= 1'b0;
          if (bitc == 3'd7) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bitc <= bitc + 3'd1;
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + DW'(1);
      end
    end
  end

  assign sclk = sclk_q;
  assign mosi = sh[7];
  assign done = done_q;
  assign rx   = rx_q;
endmodule

// File: rtl/ppe_seq.sv
module ppe_seq
  import ppe_pkg::*;
#(
  parameter int unsigned CS_GAP     = 4,
  parameter int unsigned PAGE_BYTES = 128,
  localparam int unsigned GW   = $clog2(CS_GAP + 1),
  localparam int unsigned IW   = $clog2(PAGE_BYTES + 6),
  localparam int unsigned BI_W = $clog2(PAGE_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  job_t            job,
  output logic            go,
  output logic [7:0]      tx,
  input  logic            done,
  input  logic [7:0]      rx,
  output logic            cs_n,
  output logic            busy,
  output logic [BI_W-1:0] buf_idx,
  input  logic [7:0]      buf_byte
);
  seq_st_t       st, after;
  job_t          job_q;
  logic [IW-1:0] idx, alen_w, total_w, nxt_w;
  logic [GW-1:0] gap;
  logic [1:0]    sh_sel;
  logic [7:0]    nxt_byte;
  logic [6:0]    unused_rx;

  assign unused_rx = rx[7:1];

  always_comb begin
    alen_w   = job_q.four_b ? IW'(4) : IW'(3);
    total_w  = IW'(1) + alen_w + (job_q.buffered ? IW'(PAGE_BYTES) : IW'(1));
    nxt_w    = idx + IW'(1);
    sh_sel   = 2'(alen_w - nxt_w);
    buf_idx  = BI_W'(idx - alen_w);
    if (nxt_w <= alen_w)      nxt_byte = job_q.addr[8*sh_sel +: 8];
    else if (job_q.buffered)  nxt_byte = buf_byte;
    else                      nxt_byte = job_q.byte0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      after <= S_PROG;
      job_q <= '0;
      cs_n  <= 1'b1;
      busy  <= 1'b0;
      go    <= 1'b0;
      tx    <= '0;
      idx   <= '0;
      gap   <= '0;
    end else begin
      go <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          job_q <= job;
          busy  <= 1'b1;
          cs_n  <= 1'b0;
          go    <= 1'b1;
          idx   <= '0;
          if (!job.no_wren) begin
            st <= S_WREN;
            tx <= OP_WREN;
          end else begin
            st <= S_PROG;
            tx <= job.opcode;
          end
        end
        S_WREN: if (done) begin
          cs_n  <= 1'b1;
          gap   <= '0;
          after <= S_PROG;
          st    <= S_GAP;
        end
        S_GAP: begin
          if (gap == GW'(CS_GAP - 1)) begin
            cs_n <= 1'b0;
            go   <= 1'b1;
            idx  <= '0;
            st   <= after;
            tx   <= (after == S_PROG) ? job_q.opcode : OP_RDSR;
          end else begin
            gap <= gap + GW'(1);
          end
        end
        S_PROG: if (done) begin
          if (idx == total_w - IW'(1)) begin
            cs_n <= 1'b1;
            if (job_q.no_poll) begin
              st <= S_DONE;
            end else begin
              gap   <= '0;
              after <= S_POLL_OP;
              st    <= S_GAP;
            end
          end else begin
            idx <= nxt_w;
            go  <= 1'b1;
            tx  <= nxt_byte;
          end
        end
        S_POLL_OP: if (done) begin
          go <= 1'b1;
          tx <= 8'h00;
          st <= S_POLL_RD;
        end
        S_POLL_RD: if (done) begin
          if (!rx[0]) begin
            cs_n <= 1'b1;
            st   <= S_DONE;
          end else begin
            go <= 1'b1;
            tx <= 8'h00;
          end
        end
        S_DONE: begin
          busy <= 1'b0;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_prog_engine.sv
module page_prog_engine
  import ppe_pkg::*;
#(
  parameter int unsigned DIV        = 2,
  parameter int unsigned CS_GAP     = 4,
  parameter int unsigned PAGE_WORDS = 32,
  localparam int unsigned PAGE_BYTES = PAGE_WORDS * 4,
  localparam int unsigned FILL_W     = $clog2(PAGE_WORDS + 1),
  localparam int unsigned BI_W       = $clog2(PAGE_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            spi_sclk,
  output logic            spi_cs_n,
  output logic            spi_mosi,
  input  logic            spi_miso
);
  logic              seq_busy, reg_start, page_wr, buf_req, buf_ack;
  logic [31:0]       page_data;
  logic [7:0]        opc_q, sh_tx, sh_rx, buf_byte;
  logic              sh_go, sh_done;
  logic [BI_W-1:0]   buf_idx;
  logic [FILL_W-1:0] buf_fill;
  job_t              job;

  ppe_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy(seq_busy), .rdata(reg_rdata), .start(reg_start), .job(job),
    .page_wr(page_wr), .page_data(page_data), .buf_req(buf_req),
    .buf_ack(buf_ack), .opc_q(opc_q)
  );

  ppe_page_buf #(.WORDS(PAGE_WORDS)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(reg_start), .wr(page_wr), .wdata(page_data),
    .rd_idx(buf_idx), .rd_byte(buf_byte), .fill(buf_fill)
  );

  ppe_seq #(.CS_GAP(CS_GAP), .PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(reg_start), .job(job), .go(sh_go),
    .tx(sh_tx), .done(sh_done), .rx(sh_rx), .cs_n(spi_cs_n), .busy(seq_busy),
    .buf_idx(buf_idx), .buf_byte(buf_byte)
  );

  ppe_spi_shift #(.DIV(DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(sh_go), .tx(sh_tx), .done(sh_done),
    .rx(sh_rx), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );
endmodule

// File: rtl/ppe_checker.sv
module ppe_checker #(
  parameter int unsigned WORDS  = 32,
  parameter int unsigned FILL_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              start,
  input logic              cs_n,
  input logic              sclk,
  input logic              mosi,
  input logic [FILL_W-1:0] fill,
  input logic              buf_req,
  input logic              buf_ack,
  input logic              wr,
  input logic [7:0]        opc
);
  p_cs_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  p_ack_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_ack) |-> $past(buf_req, 2));

  p_ack_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_ack) |-> !$past(buf_req, 2));

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(WORDS));

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr) |=> $stable(opc));

  p_sclk_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_mosi_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

bind page_prog_engine ppe_checker #(.WORDS(PAGE_WORDS), .FILL_W(FILL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(seq_busy), .start(reg_start),
  .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi), .fill(buf_fill),
  .buf_req(buf_req), .buf_ack(buf_ack), .wr(reg_wr), .opc(opc_q)
);

// File: tb/page_prog_engine_tb.sv
module page_prog_engine_tb;
  localparam int CS_GAP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  page_prog_engine #(.DIV(2), .CS_GAP(CS_GAP), .PAGE_WORDS(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  // ---------------- flash model ----------------
  logic [7:0] cap [0:1023];
  int fs [0:15];
  int fl [0:15];
  int nfrm = 0, ncap = 0, bitn = 0, poll_n = 0, busy_n = 0, rise_cyc = 0, gap_bad = 0;
  bit in_frame = 0;
  logic [7:0] cur = '0;

  always @(posedge clk) cyc++;

  always @(negedge spi_cs_n) begin
    if (nfrm > 0 && (cyc - rise_cyc) != CS_GAP) gap_bad++;
    in_frame = 1; bitn = 0; poll_n = 0;
    if (nfrm < 16) fs[nfrm] = ncap;
    spi_miso = 1'b0;
  end

  always @(posedge spi_cs_n) begin
    if (in_frame) begin
      in_frame = 0;
      if (nfrm < 16) fl[nfrm] = ncap - fs[nfrm];
      nfrm++;
      rise_cyc = cyc;
    end
  end

  function automatic bit poll_frame();
    return (nfrm < 16) && (ncap - fs[nfrm] >= 1) && (cap[fs[nfrm]] == 8'h05);
  endfunction

  always @(posedge spi_sclk) begin
    if (in_frame) begin
      cur = {cur[6:0], spi_mosi};
      bitn++;
      if (bitn == 8) begin
        bitn = 0;
        if (poll_frame()) poll_n++;
        if (ncap < 1024) cap[ncap] = cur;
        ncap++;
      end
    end
  end

  always @(negedge spi_sclk) begin
    if (in_frame) spi_miso = poll_frame() && (bitn == 7) && (poll_n < busy_n);
  end

  // ---------------- expectations ----------------
  logic [7:0] ecap [0:1023];
  int es [0:15];
  int el [0:15];
  int en = 0, encap = 0;
  logic [31:0] pw [0:31];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic exp_open(); es[en] = encap; el[en] = 0; endtask
  task automatic exp_byte(input logic [7:0] b); ecap[encap] = b; encap++; el[en]++; endtask
  task automatic exp_close(); en++; endtask

  function automatic logic [7:0] page_byte(input int j);
    return pw[j >> 2][8*(j & 3) +: 8];
  endfunction

  task automatic build_exp(input bit nowren, input bit nopoll, input bit four,
                           input bit buffered, input logic [7:0] opc,
                           input logic [31:0] addr, input logic [7:0] db, input int bn);
    en = 0; encap = 0;
    if (!nowren) begin exp_open(); exp_byte(8'h06); exp_close(); end
    exp_open();
    exp_byte(opc);
    if (four) exp_byte(addr[31:24]);
    exp_byte(addr[23:16]); exp_byte(addr[15:8]); exp_byte(addr[7:0]);
    if (buffered) for (int j = 0; j < 128; j++) exp_byte(page_byte(j));
    else exp_byte(db);
    exp_close();
    if (!nopoll) begin
      exp_open(); exp_byte(8'h05);
      for (int k = 0; k <= bn; k++) exp_byte(8'h00);
      exp_close();
    end
  endtask

  task automatic compare(input string req);
    chk(nfrm == en, req, "frame count", nfrm, en);
    for (int f = 0; f < en && f < nfrm && f < 16; f++) begin
      bit ok = (fl[f] == el[f]);
      int bad = -1;
      if (ok) for (int b = 0; b < el[f]; b++)
        if (cap[fs[f] + b] !== ecap[es[f] + b] && bad < 0) begin ok = 0; bad = b; end
      if (bad >= 0) chk(ok, req, $sformatf("frame %0d byte %0d", f, bad),
                        cap[fs[f] + bad], ecap[es[f] + bad]);
      else chk(ok, req, $sformatf("frame %0d length", f), fl[f], el[f]);
    end
  endtask

  // ---------------- register access ----------------
  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    do begin @(negedge clk); reg_read(4'd0, v); end while (v[4]);
  endtask

  bit cust_on = 0, buf_on = 0;

  task automatic run_op(input bit nowren, input bit nopoll, input bit four,
                        input bit cust, input logic [7:0] opc, input logic [31:0] addr,
                        input logic [7:0] db, input int bn, input bit poke, input string req);
    logic [31:0] v;
    cust_on = cust;
    reg_write(4'd1, {24'd0, opc});
    reg_write(4'd2, {24'd0, addr[7:0]});
    reg_write(4'd3, {24'd0, addr[15:8]});
    reg_write(4'd4, {24'd0, addr[23:16]});
    reg_write(4'd5, {24'd0, addr[31:24]});
    reg_write(4'd6, {27'd0, four, 4'd0});
    reg_write(4'd7, {27'd0, cust, 3'd0, buf_on});
    reg_write(4'd8, {24'd0, nowren, 1'b0, nopoll, 5'd0});
    reg_write(4'd9, {24'd0, db});
    busy_n = bn; nfrm = 0; ncap = 0;
    reg_write(4'd0, 32'h10);
    reg_read(4'd0, v);
    chk(v[4] == 1'b1, "R2", "busy after start", v[4], 1);
    if (poke) begin
      reg_write(4'd1, 32'hEE);
      reg_write(4'd0, 32'h10);
      reg_write(4'd10, 32'hDEADBEEF);
    end
    wait_idle();
    reg_read(4'd0, v);
    chk(v[4] == 1'b0, "R2", "start bit cleared", v[4], 0);
    build_exp(nowren, nopoll, four, buf_on, cust ? opc : 8'h02,
              four ? addr : {8'd0, addr[23:0]}, db, bn);
    repeat (10) @(negedge clk);
    compare(req);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1234_5EED));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(4'd0, v); chk(v == 0, "R1", "CTRL after reset", v, 0);
    reg_read(4'd1, v); chk(v == 0, "R1", "OPCODE after reset", v, 0);
    reg_read(4'd7, v); chk(v == 0, "R1", "WRCFG after reset", v, 0);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1", "pins idle",
        {spi_cs_n, spi_sclk}, 2'b10);

    // R3 default opcode, R4 3-byte, R5 wren frame, R6 poll, R10 one byte
    run_op(0, 0, 0, 0, 8'h77, 32'hAB12_3456, 8'hC3, 2, 0, "R3 R4 R5 R6 R10");
    // R3 custom opcode, R4 four-byte address
    run_op(0, 0, 1, 1, 8'h32, 32'h9A87_6543, 8'h5A, 0, 0, "R3 R4");
    // R5 R6 both disabled: single frame
    run_op(1, 1, 0, 1, 8'h12, 32'h0001_0203, 8'hF0, 3, 0, "R5 R6");

    // R7 buffer handshake
    reg_write(4'd7, 32'h1);
    reg_read(4'd7, v); chk(v[0] == 1'b0, "R7", "ack not yet", v[0], 0);
    @(negedge clk); @(negedge clk);
    reg_read(4'd7, v); chk(v[0] == 1'b1, "R7", "ack after two cycles", v[0], 1);
    buf_on = 1;

    // R8 R9: 33 words, last dropped
    for (int w = 0; w < 32; w++) begin
      pw[w] = $urandom();
      reg_write(4'd10, pw[w]);
    end
    reg_write(4'd10, 32'h0BAD_F00D);
    run_op(0, 0, 0, 0, 8'h00, 32'h0012_3400, 8'h00, 4, 0, "R8 R9");

    // R9 pointer reset, R11 writes during busy ignored
    for (int w = 0; w < 32; w++) begin
      pw[w] = $urandom();
      reg_write(4'd10, pw[w]);
    end
    run_op(1, 0, 1, 1, 8'h3E, 32'h4455_6677, 8'h00, 1, 1, "R9 R11");
    reg_read(4'd1, v); chk(v[7:0] == 8'h3E, "R11", "opcode kept", v[7:0], 8'h3E);

    // R7 disable handshake, R10 back to one byte
    reg_write(4'd7, 32'h0);
    reg_read(4'd7, v); chk(v[0] == 1'b1, "R7", "ack still set", v[0], 1);
    @(negedge clk); @(negedge clk);
    reg_read(4'd7, v); chk(v[0] == 1'b0, "R7", "ack cleared", v[0], 0);
    buf_on = 0;
    run_op(0, 1, 0, 0, 8'h00, 32'h00FF_EE01, 8'h81, 0, 0, "R10");

    // random unbuffered sequences
    for (int r = 0; r < 8; r++) begin
      run_op(1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
             8'($urandom()), $urandom(), 8'($urandom()), int'($urandom() % 4), 0,
             "R3 R4 R5 R6 R10 random");
    end

    chk(gap_bad == 0, "R12", "chip-select gap", gap_bad, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule